// File: doc/BRIEF.md
# Serial Audio Transmitter with Sample Packing

This block turns audio sample words into a three-wire serial stream: a bit clock, a channel-select line and a data line. The host writes 32-bit words into an eight-entry queue. The transmitter pulls one or two words per frame, depending on the packing mode, and shifts the samples out MSB first. A frame is two 32-bit-clock slots, left then right.

The bit clock comes from a clock-enable input. Each enable pulse toggles the bit clock. Outgoing data and channel select change only when the bit clock falls. Three framings are supported: I2S, left-justified and right-justified. Four packing modes decide how a queue word is split into channel samples: stereo, mono, two 16-bit halves, or two bytes.

When the queue has no word at the moment a sample is needed, the block sends silence and raises a sticky underrun flag. Configuration is expected to be held steady while the bit clock runs.

Top module: `aud_tx`

## Requirements
- R1: After reset, bclk, ws, sd and underrun are low, fifo_level is 0 and fifo_full is low.
- R2: The queue holds 8 words. fifo_full is high when 8 are held. A write presented while full is dropped and never transmitted.
- R3: Each cycle with bclk_tick high toggles bclk. bclk holds its value in any cycle without a tick. One bit period is therefore two ticks.
- R4: A tick while bclk is high is a falling edge, and only a falling edge changes sd and ws. A frame is 64 bit periods: slot bits 0–31 are the left channel and 32–63 are the right. The first falling edge after reset starts a frame.
- R5: cfg_fmt selects the framing: 0 is I2S, 1 is left-justified, 2 is right-justified, and 3 acts as left-justified. In the justified framings, ws is low for the whole left slot and high for the whole right slot. In I2S, ws changes one bit period before each slot starts, so the sample MSB follows the ws edge by one bit clock.
- R6: In I2S and left-justified framing, a W-bit sample goes out MSB first in slot bits 0..W-1, and the rest of the slot is zero.
- R7: In right-justified framing, the sample LSB falls in the last bit of the slot and the MSB in bit 32-W. Earlier bits are zero.
- R8: In stereo packing (cfg_pack 0), W is cfg_wlen+1. Each word supplies one sample from its low W bits. Words go alternately to left and right, starting with left; the left word is taken at the frame start and the right word at the slot midpoint.
- R9: In mono packing (cfg_pack 1), one word per frame supplies a W = cfg_wlen+1 bit sample from its low bits. That sample is sent on both channels.
- R10: In 16-bit compact packing (cfg_pack 2), one word per frame carries the left sample in bits 15:0 and the right sample in bits 31:16. W is 16 and cfg_wlen is ignored.
- R11: In 8-bit compact packing (cfg_pack 3), one word per frame carries the left sample in bits 7:0 and the right sample in bits 15:8. W is 8, and bits 31:16 have no effect on the output.
- R12: An empty queue at a frame start gives an all-zero frame and consumes nothing. In stereo, an empty queue at the midpoint gives a zero right slot. Either case sets underrun, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_tick | input | 1 | Clock enable; each pulse toggles the bit clock |
| cfg_fmt | input | 2 | Framing select |
| cfg_pack | input | 2 | Packing mode select |
| cfg_wlen | input | 5 | Sample width minus one (stereo and mono) |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Queue write word |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_level | output | 4 | Words held in the queue |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, low for left |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A slot counter that is off by one rotates the sample within its slot. Because it also moves the ws edges relative to the data, the fault shows inside the first frame after reset. A stereo alternation flag that gets stuck sends left words on the right channel and leaves words behind in the queue, which fifo_level exposes at the end of the stream. A latched sample width taken from the wrong mode truncates or zero-pads every sample from the next frame onward. Wrong queue bookkeeping either replays a dropped word or skips one, so it shows in the frame where the ninth write would have landed, together with a wrong underrun flag.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_ALT   = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        PK_STEREO = 2'd0,
        PK_MONO   = 2'd1,
        PK_HALF   = 2'd2,
        PK_BYTE   = 2'd3
    } pack_mode_e;

endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    fifo_state_t s_q, s_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (s_q.cnt == FULLC);
    assign empty = (s_q.cnt == '0);
    assign level = s_q.cnt;
    assign head  = mem_q[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            s_d.wp = (s_q.wp == LASTP) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop) begin
            s_d.rp = (s_q.rp == LASTP) ? '0 : s_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (do_push && (s_q.wp == PW'(gi))) begin
                mem_q[gi] <= push_data;
            end
        end
    end

endmodule

// File: rtl/aud_tx_unpack.sv
module aud_tx_unpack
    import aud_tx_pkg::*;
#(
    parameter  int DW   = 32,
    localparam int IW   = $clog2(DW),
    localparam int HALF = DW / 2,
    localparam int QTR  = DW / 4
) (
    input  logic [DW-1:0] entry,
    input  logic [1:0]    pack,
    input  logic [IW-1:0] wlen,
    output logic [DW-1:0] smp_left,
    output logic [DW-1:0] smp_right,
    output logic [IW-1:0] smp_wm1
);

    logic [DW-1:0] keep;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            keep[i] = (i <= int'(wlen));
        end
        smp_left  = '0;
        smp_right = '0;
        smp_wm1   = wlen;
        case (pack_mode_e'(pack))
            PK_STEREO: begin
                smp_left = entry & keep;
            end
            PK_MONO: begin
                smp_left  = entry & keep;
                smp_right = entry & keep;
            end
            PK_HALF: begin
                smp_left  = {{(DW-HALF){1'b0}}, entry[HALF-1:0]};
                smp_right = {{(DW-HALF){1'b0}}, entry[DW-1:HALF]};
                smp_wm1   = IW'(HALF - 1);
            end
            default: begin
                smp_left  = {{(DW-QTR){1'b0}}, entry[QTR-1:0]};
                smp_right = {{(DW-QTR){1'b0}}, entry[2*QTR-1:QTR]};
                smp_wm1   = IW'(QTR - 1);
            end
        endcase
    end

endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel #(
    parameter  int DW = 32,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0] sample,
    input  logic [IW-1:0] wm1,
    input  logic [IW-1:0] slot_bit,
    input  logic          right_just,
    output logic          bit_o
);

    localparam logic [IW-1:0] LASTB = IW'(DW - 1);

    always_comb begin
        bit_o = 1'b0;
        if (right_just) begin
            if (slot_bit >= (LASTB - wm1)) begin
                bit_o = sample[LASTB - slot_bit];
            end
        end else if (slot_bit <= wm1) begin
            bit_o = sample[wm1 - slot_bit];
        end
    end

endmodule

// File: rtl/aud_tx.sv
module aud_tx
    import aud_tx_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int DW    = 32,
    localparam int IW    = $clog2(DW),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_tick,
    input  logic [1:0]    cfg_fmt,
    input  logic [1:0]    cfg_pack,
    input  logic [IW-1:0] cfg_wlen,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          fifo_full,
    output logic [CW-1:0] fifo_level,
    output logic          bclk,
    output logic          ws,
    output logic          sd,
    output logic          underrun
);

    typedef struct packed {
        logic          bclk;
        logic [IW:0]   pos;
        logic          ws;
        logic          sd;
        logic [DW-1:0] lft;
        logic [DW-1:0] rgt;
        logic [IW-1:0] wm1;
        logic          rgt_pend;
        logic          urun;
    } tx_state_t;

    localparam logic [IW:0] MID = (IW+1)'(DW);

    tx_state_t s_q, s_d;

    logic          pop, fifo_empty;
    logic [DW-1:0] head;
    logic [DW-1:0] u_left, u_right;
    logic [IW-1:0] u_wm1;
    logic          fall;
    logic [IW:0]   pos_d, lead_d;
    logic [DW-1:0] lft_d, rgt_d;
    logic [IW-1:0] wm1_d;
    logic          pend_d, urun_d;
    logic          out_bit;
    frame_fmt_e    fmt;

    assign fmt = frame_fmt_e'(cfg_fmt);

    aud_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    aud_tx_unpack #(.DW(DW)) i_unpack (
        .entry     (head),
        .pack      (cfg_pack),
        .wlen      (cfg_wlen),
        .smp_left  (u_left),
        .smp_right (u_right),
        .smp_wm1   (u_wm1)
    );

    // Slot position and sample registers for the bit about to be driven.
    always_comb begin
        fall   = bclk_tick && s_q.bclk;
        pos_d  = s_q.pos;
        lft_d  = s_q.lft;
        rgt_d  = s_q.rgt;
        wm1_d  = s_q.wm1;
        pend_d = s_q.rgt_pend;
        urun_d = s_q.urun;
        pop    = 1'b0;
        if (fall) begin
            pos_d = s_q.pos + 1'b1;
            if (pos_d == '0) begin
                if (fifo_empty) begin
                    lft_d  = '0;
                    rgt_d  = '0;
                    pend_d = 1'b0;
                    urun_d = 1'b1;
                end else begin
                    pop    = 1'b1;
                    lft_d  = u_left;
                    rgt_d  = u_right;
                    wm1_d  = u_wm1;
                    pend_d = (pack_mode_e'(cfg_pack) == PK_STEREO);
                end
            end else if ((pos_d == MID) && s_q.rgt_pend) begin
                pend_d = 1'b0;
                if (fifo_empty) begin
                    rgt_d  = '0;
                    urun_d = 1'b1;
                end else begin
                    pop   = 1'b1;
                    rgt_d = u_left;
                end
            end
        end
        lead_d = pos_d + 1'b1;
    end

    aud_tx_bitsel #(.DW(DW)) i_bitsel (
        .sample     (pos_d[IW] ? rgt_d : lft_d),
        .wm1        (wm1_d),
        .slot_bit   (pos_d[IW-1:0]),
        .right_just (fmt == FMT_RIGHT),
        .bit_o      (out_bit)
    );

    always_comb begin
        s_d = s_q;
        if (bclk_tick) begin
            s_d.bclk = !s_q.bclk;
        end
        if (fall) begin
            s_d.pos      = pos_d;
            s_d.lft      = lft_d;
            s_d.rgt      = rgt_d;
            s_d.wm1      = wm1_d;
            s_d.rgt_pend = pend_d;
            s_d.sd       = out_bit;
            s_d.ws       = (fmt == FMT_I2S) ? lead_d[IW] : pos_d[IW];
        end
        s_d.urun = urun_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pos <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bclk     = s_q.bclk;
    assign ws       = s_q.ws;
    assign sd       = s_q.sd;
    assign underrun = s_q.urun;

endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bclk_tick,
    input logic          wr_en,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_level,
    input logic          bclk,
    input logic          ws,
    input logic          sd,
    input logic          underrun
);

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CW'(DEPTH));

    assert_full_no_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en) |=> (fifo_level <= $past(fifo_level)));

    assert_bclk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_tick |=> $stable(bclk));

    assert_bclk_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_tick |=> (bclk != $past(bclk)));

    assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_tick && bclk) |=> ($stable(sd) && $stable(ws)));

    assert_underrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

endmodule

bind aud_tx aud_tx_chk #(.DEPTH(DEPTH)) i_aud_tx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_tick  (bclk_tick),
    .wr_en      (wr_en),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level),
    .bclk       (bclk),
    .ws         (ws),
    .sd         (sd),
    .underrun   (underrun)
);

// File: tb/test_aud_tx.sv
module test_aud_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_tick = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  cfg_pack = 2'd0;
    logic [4:0]  cfg_wlen = 5'd31;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        fifo_full;
    logic [3:0]  fifo_level;
    logic        bclk, ws, sd, underrun;

    always #2 clk = !clk;

    aud_tx i_aud_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_tick  (bclk_tick),
        .cfg_fmt    (cfg_fmt),
        .cfg_pack   (cfg_pack),
        .cfg_wlen   (cfg_wlen),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .fifo_full  (fifo_full),
        .fifo_level (fifo_level),
        .bclk       (bclk),
        .ws         (ws),
        .sd         (sd),
        .underrun   (underrun)
    );

    int checks = 0;
    int errors = 0;

    // capture of (ws, sd) at each rising bit-clock edge
    logic cap_ws [0:1023];
    logic cap_sd [0:1023];
    int   cap_cyc [0:1023];
    logic exp_ws [0:1023];
    logic exp_sd [0:1023];
    int   cap_n = 0;
    int   stop_at = 0;
    int   gap = 1;
    int   gcnt = 0;
    int   cyc = 0;
    logic tick_en = 1'b0;
    logic prev_b = 1'b0;

    logic [31:0] ent [0:15];
    int          ent_n = 0;
    logic        exp_urun = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            prev_b    = 1'b0;
            cap_n     = 0;
            bclk_tick = 1'b0;
            gcnt      = 0;
        end else begin
            if (bclk && !prev_b && cap_n < 1024) begin
                cap_ws[cap_n]  = ws;
                cap_sd[cap_n]  = sd;
                cap_cyc[cap_n] = cyc;
                cap_n = cap_n + 1;
            end
            prev_b = bclk;
            if (tick_en && cap_n < stop_at) begin
                gcnt = gcnt + 1;
                bclk_tick = ((gcnt % gap) == 0);
            end else begin
                bclk_tick = 1'b0;
                gcnt = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset(input int fmt, input int pack, input int wlen);
        @(negedge clk);
        rst_n    = 1'b0;
        tick_en  = 1'b0;
        gap      = 1;
        cfg_fmt  = 2'(fmt);
        cfg_pack = 2'(pack);
        cfg_wlen = 5'(wlen);
        ent_n    = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        if (ent_n < 8) begin
            ent[ent_n] = v;
            ent_n = ent_n + 1;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic pick(input logic [31:0] s, input int w,
                                  input int k, input int fmt);
        if (fmt == 2) return (k >= 32 - w) ? s[31-k] : 1'b0;
        return (k < w) ? s[w-1-k] : 1'b0;
    endfunction

    // independent model of the frame stream
    task automatic build(input int fmt, input int pack, input int wlen, input int frames);
        int idx = 0;
        logic [31:0] mask;
        mask = (wlen == 31) ? 32'hFFFF_FFFF : ((32'h1 << (wlen + 1)) - 1);
        exp_urun = 1'b0;
        for (int f = 0; f < frames; f++) begin
            logic [31:0] lv, rv;
            int w;
            lv = '0; rv = '0; w = wlen + 1;
            if (idx >= ent_n) begin
                exp_urun = 1'b1;
            end else begin
                case (pack)
                    0: begin
                        lv = ent[idx] & mask; idx = idx + 1;
                        if (idx < ent_n) begin rv = ent[idx] & mask; idx = idx + 1; end
                        else exp_urun = 1'b1;
                    end
                    1: begin lv = ent[idx] & mask; rv = lv; idx = idx + 1; end
                    2: begin lv = {16'h0, ent[idx][15:0]}; rv = {16'h0, ent[idx][31:16]};
                             w = 16; idx = idx + 1; end
                    default: begin lv = {24'h0, ent[idx][7:0]}; rv = {24'h0, ent[idx][15:8]};
                             w = 8; idx = idx + 1; end
                endcase
            end
            for (int p = 0; p < 64; p++) begin
                int r = 64 * f + p + 1;
                exp_ws[r] = (fmt == 0) ? (((p + 1) % 64) >= 32) : (p >= 32);
                exp_sd[r] = pick((p < 32) ? lv : rv, w, p % 32, fmt);
            end
        end
    endtask

    task automatic run_stream(input string req, input int frames);
        int mism = 0;
        int first = -1;
        stop_at = 64 * frames + 1;
        tick_en = 1'b1;
        while (cap_n < stop_at) @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
        for (int r = 1; r <= 64 * frames; r++) begin
            if (cap_ws[r] !== exp_ws[r] || cap_sd[r] !== exp_sd[r]) begin
                mism = mism + 1;
                if (first < 0) first = r;
            end
        end
        if (mism != 0)
            $display("  first mismatch at bit %0d: ws=%0b/%0b sd=%0b/%0b", first,
                     cap_ws[first], exp_ws[first], cap_sd[first], exp_sd[first]);
        check(mism == 0, req, "mismatching bits", mism, 0);
    endtask

    task automatic t_reset;
        do_reset(1, 0, 31);
        @(negedge clk);
        check({bclk, ws, sd, underrun, fifo_full} == 5'b0 && fifo_level == 4'd0,
              "R1", "reset outputs", int'({bclk, ws, sd, underrun, fifo_full, fifo_level}), 0);
    endtask

    task automatic t_full_mono;
        do_reset(1, 1, 31);
        for (int i = 0; i < 9; i++) push(32'h8000_0001 + 32'(i) * 32'h0101_0101);
        @(negedge clk);
        check(fifo_full == 1'b1, "R2", "full flag", int'(fifo_full), 1);
        check(fifo_level == 4'd8, "R2", "level after 9 writes", int'(fifo_level), 8);
        build(1, 1, 31, 9);
        run_stream("R2/R9 mono LJ w32 dropped ninth word", 9);
        check(underrun == exp_urun, "R12", "underrun after drain", int'(underrun), int'(exp_urun));
    endtask

    task automatic t_stereo_i2s;
        do_reset(0, 0, 23);
        push(32'hFFA5_C3E1); push(32'h0012_3456); push(32'h7F80_0001);
        push(32'hAB80_0000); push(32'h00FF_FFFF); push(32'h5555_AAAA);
        build(0, 0, 23, 3);
        run_stream("R5/R6/R8 stereo I2S w24", 3);
        check(underrun == 1'b0, "R12", "no underrun with exact data", int'(underrun), 0);
        check(fifo_level == 4'd0, "R8", "all stereo words consumed", int'(fifo_level), 0);
    endtask

    task automatic t_stereo_odd;
        do_reset(1, 0, 15);
        push(32'h0000_8001); push(32'h1234_F00F); push(32'hFFFF_C3A5);
        build(1, 0, 15, 2);
        run_stream("R8/R12 stereo LJ w16 missing right", 2);
        check(underrun == 1'b1, "R12", "underrun at midpoint", int'(underrun), 1);
    endtask

    task automatic t_mono_rj;
        do_reset(2, 1, 19);
        push(32'hFFF8_0003); push(32'h0004_5A5A);
        build(2, 1, 19, 2);
        run_stream("R7/R9 mono RJ w20", 2);
        check(underrun == 1'b0, "R12", "no underrun mono", int'(underrun), 0);
    endtask

    task automatic t_half_i2s;
        do_reset(0, 2, 3);
        push(32'h8001_7FFE); push(32'h00FF_FF00);
        build(0, 2, 3, 2);
        run_stream("R10 compact16 I2S", 2);
    endtask

    task automatic t_byte_rj_slow;
        do_reset(2, 3, 31);
        gap = 3;
        push(32'hDEAD_81C3); push(32'hFFFF_7E01);
        build(2, 3, 31, 2);
        run_stream("R11 compact8 RJ sparse ticks", 2);
        check(cap_cyc[2] - cap_cyc[1] == 6, "R3", "cycles per bit period at gap 3",
              cap_cyc[2] - cap_cyc[1], 6);
    endtask

    task automatic t_stereo_w32;
        do_reset(1, 0, 31);
        push(32'h8000_0001); push(32'hC0FF_EE03);
        build(1, 0, 31, 1);
        run_stream("R4/R6 stereo LJ full width", 1);
    endtask

    initial begin
        t_reset();
        t_full_mono();
        t_stereo_i2s();
        t_stereo_odd();
        t_mono_rj();
        t_half_i2s();
        t_byte_rj_slow();
        t_stereo_w32();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule